// File: doc/BRIEF.md
# Clock Synthesizer Serial Loader

This block loads a 24-bit control word into an external programmable frequency synthesizer over a two-wire clock-and-data link. A one-cycle start strobe latches the word. The block then drives a fixed unlock preamble on the two lines, followed by the serialized word and a short stop pattern. Each bit of the word uses a four-step line pattern, and the order of that pattern depends on the bit value. At the end the block leaves the 2-bit clock-select field of the word on the lines, where it selects the synthesizer output.

Every line state is held for `PHASE_CYCLES` system clocks, so the link can be slowed to suit the synthesizer. `busy_o` is high for the whole transfer. `done_o` marks the cycle in which the select code is first driven. Divider computation and display blanking are done elsewhere.

Top module: `synth_loader`

## Requirements
- R1: After reset, lines_o is 2'b00, and busy_o and done_o are low until the first accepted start.
- R2: lines_o[1] is the data wire and lines_o[0] is the clock wire, giving the codes NONE=00, CLK=01, DATA=10 and BOTH=11. A start seen while idle is accepted at that clock edge: busy_o rises and lines_o shows NONE from the same edge.
- R3: The first 18 phases form the preamble: NONE, DATA, then six pairs of BOTH followed by DATA, then NONE, CLK, NONE, CLK.
- R4: After the preamble, exactly 24 bits are sent in 4 phases each. Bit slot i (0..23) carries word bit i+1, and word bit 24 counts as 0. Word bit 0 is never sent.
- R5: A one bit is sent as the phases CLK, NONE, DATA, BOTH.
- R6: A zero bit is sent as the phases BOTH, DATA, NONE, CLK.
- R7: After the last bit, the stop pattern BOTH, DATA, BOTH is driven.
- R8: Every phase holds lines_o for exactly PHASE_CYCLES clocks, and phase changes happen only at clock edges.
- R9: When the stop pattern ends, lines_o takes word bits 23:22 and keeps them until the next accepted start. done_o is high for that single cycle, and busy_o falls in the same cycle.
- R10: A start that arrives while busy_o is high is ignored. The word is latched on acceptance, so later changes on word_i have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled on clock edges |
| word_i | input | 24 | Control word; bits 23:22 are the clock select |
| lines_o | output | 2 | Link state: bit 1 data, bit 0 clock |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the select code is first driven |

## Verification
The assertions assume that start_i and word_i change only between clock edges and are clean after reset. They make no assumption about when start_i is raised. The bench drives all inputs on falling edges. It raises start_i both while idle and in the middle of a transfer, and it scrambles word_i after every acceptance. This shows that the ignored strobe and the unlatched input leave the line sequence unchanged. The words sent are a walking one across every position, plus all-zero, all-one and alternating patterns. Each phase of each transfer is compared with a sequence that the bench computes arithmetically.

// File: rtl/synth_loader_pkg.sv
package synth_loader_pkg;
  typedef enum logic [1:0] {
    LN_NONE = 2'b00,
    LN_CLK  = 2'b01,
    LN_DATA = 2'b10,
    LN_BOTH = 2'b11
  } line_t;

  localparam int unsigned PRE_LEN  = 18;
  localparam int unsigned BIT_PH   = 4;
  localparam int unsigned STOP_LEN = 3;
  localparam int unsigned PAIR_CNT = 6;
endpackage

// File: rtl/synth_loader_timer.sv
module synth_loader_timer #(
  parameter int unsigned PHASE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else if (run_i)    cnt_q <= cnt_q + 1'b1;
  end

  // R8: counter never runs past the phase length
  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
endmodule

// File: rtl/synth_loader_shifter.sv
module synth_loader_shifter #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o,
  output logic [1:0]        sel_o
);
  logic [WORD_W-1:0] sr_q;
  logic [1:0]        sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      sel_q <= 2'b00;
    end else if (load_i) begin
      // pre-shift: slot 0 carries word bit 1, a zero enters from the top
      sr_q  <= {1'b0, word_i[WORD_W-1:1]};
      sel_q <= word_i[WORD_W-1 -: 2];
    end else if (shift_i) begin
      sr_q  <= {1'b0, sr_q[WORD_W-1:1]};
    end
  end

  assign bit_o = sr_q[0];
  assign sel_o = sel_q;

  // R10: select held between loads
  a_r10_sel_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(sel_o));
endmodule

// File: rtl/synth_loader_encoder.sv
module synth_loader_encoder
  import synth_loader_pkg::*;
#(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned IDX_W  = 7
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bit_i,
  output line_t            code_o,
  output logic             bit_end_o
);
  localparam int unsigned BITS_END = PRE_LEN + WORD_W * BIT_PH;
  localparam int unsigned PAIR_END = 2 + 2 * PAIR_CNT;

  int unsigned k;
  int unsigned rel;
  logic [1:0]  ph;
  logic [1:0]  one_pat;

  always_comb begin
    k         = int'(idx_i);
    rel       = 0;
    ph        = 2'b00;
    one_pat   = 2'b00;
    code_o    = LN_NONE;
    bit_end_o = 1'b0;
    if (k < PRE_LEN) begin
      if (k == 0)             code_o = LN_NONE;
      else if (k == 1)        code_o = LN_DATA;
      else if (k < PAIR_END)  code_o = k[0] ? LN_DATA : LN_BOTH;
      else                    code_o = k[0] ? LN_CLK  : LN_NONE;
    end else if (k < BITS_END) begin
      rel     = k - PRE_LEN;
      ph      = rel[1:0];
      // one: CLK NONE DATA BOTH; zero flips the data wire
      one_pat = {ph[1], ~(ph[1] ^ ph[0])};
      code_o  = line_t'(bit_i ? one_pat : (one_pat ^ 2'b10));
      bit_end_o = (ph == 2'b11);
    end else begin
      rel    = k - BITS_END;
      code_o = (rel == 1) ? LN_DATA : LN_BOTH;
    end
  end
endmodule

// File: rtl/synth_loader.sv
module synth_loader
  import synth_loader_pkg::*;
#(
  parameter int unsigned WORD_W       = 24,
  parameter int unsigned PHASE_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [1:0]        lines_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned N_PH  = PRE_LEN + WORD_W * BIT_PH + STOP_LEN;
  localparam int unsigned IDX_W = $clog2(N_PH);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_PH - 1);

  logic             busy_q, done_q;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       hold_q;
  logic             accept, tick, last, bit_end, cur_bit;
  logic [1:0]       sel;
  line_t            code;

  assign accept = start_i && !busy_q;
  assign last   = (idx_q == IDX_LAST);

  synth_loader_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .run_i  (busy_q),
    .tick_o (tick)
  );

  synth_loader_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .shift_i (tick && bit_end),
    .word_i  (word_i),
    .bit_o   (cur_bit),
    .sel_o   (sel)
  );

  synth_loader_encoder #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_enc (
    .idx_i     (idx_q),
    .bit_i     (cur_bit),
    .code_o    (code),
    .bit_end_o (bit_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      hold_q <= 2'b00;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (tick) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          hold_q <= sel;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign lines_o = busy_q ? code : hold_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;

  // R2: accepted start enters the first phase at once
  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && lines_o == 2'b00));
  // R8: lines only move on a phase tick while busy
  a_r8_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick) |=> $stable(lines_o));
  // R9: done and busy exclusive, done single cycle
  a_r9_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_sel_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lines_o == sel));
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> (!busy_o && $stable(lines_o)));
  // R10: busy cannot drop before the final phase ends
  a_r10_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(tick && last)) |=> busy_o);
endmodule

// File: tb/synth_loader_test.sv
`timescale 1ns/1ps
module synth_loader_test;
  localparam int P     = 3;
  localparam int NPH   = 18 + 96 + 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] word = '0;
  logic [1:0]  lines;
  logic        busy, done;
  int          checks = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  synth_loader #(.WORD_W(24), .PHASE_CYCLES(P)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .word_i(word),
    .lines_o(lines), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected line code for phase k of word w
  function automatic logic [1:0] exp_code(input logic [23:0] w, input int k);
    int b, p;
    logic v;
    if (k == 0) return 2'b00;
    if (k == 1) return 2'b10;
    if (k < 14) return (k % 2 == 0) ? 2'b11 : 2'b10;
    if (k < 18) return (k % 2 == 0) ? 2'b00 : 2'b01;
    if (k < 114) begin
      b = (k - 18) / 4;
      p = (k - 18) % 4;
      v = (b + 1 < 24) ? w[b + 1] : 1'b0;
      if (v) case (p) 0: return 2'b01; 1: return 2'b00; 2: return 2'b10; default: return 2'b11; endcase
      else   case (p) 0: return 2'b11; 1: return 2'b10; 2: return 2'b00; default: return 2'b01; endcase
    end
    return (k == 115) ? 2'b10 : 2'b11;
  endfunction

  function automatic string req_of(input int k);
    if (k < 18)  return "R3";
    if (k < 114) return "R4/R5/R6/R8";
    return "R7";
  endfunction

  task automatic run_word(input logic [23:0] w, input bit poke);
    @(negedge clk);
    start = 1'b1;
    word  = w;
    @(negedge clk);
    start = 1'b0;
    word  = ~w ^ 24'h5a5a5a;  // R10: later input must not matter
    for (int k = 0; k < NPH; k++) begin
      for (int c = 0; c < P; c++) begin
        chk(lines == exp_code(w, k), req_of(k), lines, exp_code(w, k));
        chk(busy && !done, "R2/R10 busy", {busy, done}, 2);
        if (poke && k == 60 && c == 0) begin
          start = 1'b1;
          word  = 24'hffffff ^ w;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
      end
    end
    start = 1'b0;
    chk(done && !busy, "R9 done", {busy, done}, 1);
    chk(lines == w[23:22], "R9 sel", lines, w[23:22]);
    @(negedge clk);
    chk(!done && !busy, "R9 pulse", {busy, done}, 0);
    for (int i = 0; i < 4; i++) begin
      chk(lines == w[23:22], "R9 hold", lines, w[23:22]);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(lines == 2'b00, "R1 lines", lines, 0);
    chk(!busy && !done, "R1 flags", {busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    word = 24'hc00000;
    @(negedge clk);
    chk(lines == 2'b00 && !busy && !done, "R1 idle", {lines, busy, done}, 0);
    run_word(24'h000000, 1'b0);
    run_word(24'hffffff, 1'b1);
    run_word(24'haaaaaa, 1'b0);
    run_word(24'h555555, 1'b1);
    run_word(24'h800001, 1'b0);
    for (int i = 0; i < 24; i++) run_word(24'(1) << i, (i % 3) == 0);
    run_word(24'h7e13c9, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule